// File: doc/BRIEF.md
# Two-Function Card Configuration Register Block

This block holds the card configuration registers for a combined network and modem card. Two functions, a LAN function and a modem function, each own a set of four byte registers in attribute memory: an option register, a status register, and a low and a high byte of an I/O base address. The host reaches them with attribute-space writes and reads. The write strobe arrives already qualified by the attribute-space select, so this block only decodes the offset.

From these registers the block drives the per-function controls. Each function has a soft-reset output, a function-enable output and a power-down pin whose active level is set by a strap. The block also steers each function's interrupt to the card's interrupt request line or, for the modem only, to the status-change line. Interrupts are level signals that follow their source.

For every I/O address the host presents, the block tells each function whether the address belongs to it. A function either accepts every address, or only those inside a 32-byte window anchored at its programmed base.

Top module: `ccr_dual_cfg`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 except the two option registers, which read 0x40. The outputs are then `ireq_n`=1, `stschg_n`=1, both soft-reset outputs 0, both enable outputs 0 and both I/O hits 0.
- R2: The LAN registers sit at offsets 0x3C0 (option), 0x3C2 (status), 0x3CA (base low) and 0x3CC (base high). The modem registers sit at 0x3E0, 0x3E2, 0x3EA and 0x3EC. Odd offsets and all other offsets read 0x00, and writes to them change nothing.
- R3: The option register fields are: bit 0 enable, bit 1 base-limit enable, bit 2 interrupt enable, bit 3 steer-to-status-change (modem only, always 0 on LAN), bit 7 soft reset. Bit 6 always reads 1 because interrupts are level-mode only. Bits 4 and 5 read 0.
- R4: Option bit 7 drives that function's soft-reset output. While bit 7 is set, every other bit of that function's registers reads 0 and writes to them are ignored. Clearing bit 7 leaves the hardware-reset values, and the other function is untouched.
- R5: A function whose enable bit is 0 produces no I/O hit and no interrupt, whatever its limit and interrupt-enable bits hold. Its enable output mirrors option bit 0.
- R6: An enabled function with base-limit 0 claims every I/O address. With base-limit 1, it claims only addresses whose bits [15:5] equal bits [15:5] of {base high, base low}.
- R7: The LAN request drives `ireq_n` low when the LAN function is enabled with interrupts enabled. The modem request goes to `ireq_n` when steer is 0 and to `stschg_n` when steer is 1, and never to both. Both outputs are active-low levels that stay asserted for as long as the source stays high.
- R8: Status bit 1 is read-only. It shows the function's raw interrupt source level, or 0 while that function is in soft reset.
- R9: Status bit 2 is a read/write power-down bit. The function's power-down pin equals this bit when its strap was high during reset, and its inverse otherwise. Straps are sampled only while reset is held.
- R10: A register write takes effect at the clock edge that samples the write strobe. Reads return data combinationally from the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_wr | input | 1 | Attribute-space write strobe, one cycle per write |
| attr_addr | input | 10 | Attribute byte offset |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Read data for `attr_addr` |
| io_addr | input | 16 | I/O address to qualify |
| strap_lan_pd_hi | input | 1 | LAN power-down pin active-high strap |
| strap_mdm_pd_hi | input | 1 | Modem power-down pin active-high strap |
| lan_irq_src | input | 1 | LAN interrupt source level |
| mdm_irq_src | input | 1 | Modem interrupt source level |
| lan_srst | output | 1 | LAN soft reset |
| mdm_srst | output | 1 | Modem soft reset |
| lan_en | output | 1 | LAN function enabled |
| mdm_en | output | 1 | Modem function enabled |
| lan_pd_pin | output | 1 | LAN power-down pin |
| mdm_pd_pin | output | 1 | Modem power-down pin |
| lan_io_hit | output | 1 | I/O address claimed by LAN |
| mdm_io_hit | output | 1 | I/O address claimed by modem |
| ireq_n | output | 1 | Interrupt request, active low |
| stschg_n | output | 1 | Status-change line, active low |

## Verification
Some properties are checked on every cycle. A disabled function never claims an address, and a status-change assertion always comes from an enabled modem with a live source. Odd offsets always read zero, and a soft-reset function holds cleared state. Power-down pins and base registers move only after a write, and a level request stays asserted while its source holds. The exact field layout, the window edges at 0x..5F/0x..60, the steer and enable combinations, the strap inversion and the independence of the two register sets need specific write sequences, so only the bench scenarios can show them.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int IO_AW    = 16;
    localparam int WIN_LOG2 = 5;
    localparam int NFUNC    = 2;
    localparam int FN_LAN   = 0;
    localparam int FN_MDM   = 1;

    localparam logic [ADDR_W-1:0] LAN_OFS = 10'h3C0;
    localparam logic [ADDR_W-1:0] MDM_OFS = 10'h3E0;

    // register slots inside a function's 32-byte attribute block
    localparam logic [4:0] SLOT_OPT  = 5'h00;
    localparam logic [4:0] SLOT_STAT = 5'h02;
    localparam logic [4:0] SLOT_BLO  = 5'h0A;
    localparam logic [4:0] SLOT_BHI  = 5'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OPT,
        SEL_STAT,
        SEL_BLO,
        SEL_BHI
    } reg_sel_e;

    typedef struct packed {
        logic srst;
        logic steer;
        logic irq_en;
        logic lim_en;
        logic fn_en;
    } opt_t;

    function automatic logic [ADDR_W-1:0] func_ofs(input int idx);
        return (idx == FN_LAN) ? LAN_OFS : MDM_OFS;
    endfunction

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] ofs);
        reg_sel_e s;
        s = SEL_NONE;
        if (addr[ADDR_W-1:5] == ofs[ADDR_W-1:5]) begin
            case (addr[4:0])
                SLOT_OPT:  s = SEL_OPT;
                SLOT_STAT: s = SEL_STAT;
                SLOT_BLO:  s = SEL_BLO;
                SLOT_BHI:  s = SEL_BHI;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ccr_func.sv
module ccr_func
    import ccr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FUNC_OFS  = LAN_OFS,
    parameter bit                HAS_STEER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_src,
    output logic [DATA_W-1:0] rdata,
    output opt_t              opt,
    output logic              pwr,
    output logic [IO_AW-1:0]  base
);

    reg_sel_e          sel;
    opt_t              opt_q;
    logic              pwr_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic              intr;
    logic              unused_wbits;

    assign sel          = decode(addr, FUNC_OFS);
    assign unused_wbits = ^wdata[6:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            opt_q <= '0;
            pwr_q <= 1'b0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_OPT: begin
                    if (wdata[7]) begin
                        opt_q      <= '0;
                        opt_q.srst <= 1'b1;
                        pwr_q      <= 1'b0;
                        lo_q       <= '0;
                        hi_q       <= '0;
                    end else begin
                        opt_q.srst   <= 1'b0;
                        opt_q.fn_en  <= wdata[0];
                        opt_q.lim_en <= wdata[1];
                        opt_q.irq_en <= wdata[2];
                        opt_q.steer  <= HAS_STEER ? wdata[3] : 1'b0;
                    end
                end
                SEL_STAT: if (!opt_q.srst) pwr_q <= wdata[2];
                SEL_BLO:  if (!opt_q.srst) lo_q  <= wdata;
                SEL_BHI:  if (!opt_q.srst) hi_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign intr = irq_src & ~opt_q.srst;

    always_comb begin
        case (sel)
            SEL_OPT:  rdata = {opt_q.srst, 1'b1, 2'b00, opt_q.steer,
                               opt_q.irq_en, opt_q.lim_en, opt_q.fn_en};
            SEL_STAT: rdata = {5'b0, pwr_q, intr, 1'b0};
            SEL_BLO:  rdata = lo_q;
            SEL_BHI:  rdata = hi_q;
            default:  rdata = '0;
        endcase
    end

    assign opt  = opt_q;
    assign pwr  = pwr_q;
    assign base = IO_AW'({hi_q, lo_q});

    AST_SRST_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        opt_q.srst |-> (!pwr_q && lo_q == '0 && hi_q == '0 && !opt_q.fn_en)) // R4
        else $error("soft reset state not clear");

    AST_BASE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable({hi_q, lo_q})) // R10
        else $error("base moved without write");

endmodule

// File: rtl/ccr_io_match.sv
module ccr_io_match
    import ccr_pkg::*;
(
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_AW-1:0] base,
    input  logic             fn_en,
    input  logic             lim_en,
    output logic             pass
);

    localparam int TAG_W = IO_AW - WIN_LOG2;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;
    logic             unused_low;

    assign addr_tag   = io_addr[IO_AW-1:WIN_LOG2];
    assign base_tag   = base[IO_AW-1:WIN_LOG2];
    assign unused_low = ^{io_addr[WIN_LOG2-1:0], base[WIN_LOG2-1:0]};
    assign pass       = fn_en & (~lim_en | (addr_tag == base_tag));

endmodule

// File: rtl/ccr_dual_cfg.sv
module ccr_dual_cfg
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              attr_wr,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic [DATA_W-1:0] attr_wdata,
    output logic [DATA_W-1:0] attr_rdata,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              strap_lan_pd_hi,
    input  logic              strap_mdm_pd_hi,
    input  logic              lan_irq_src,
    input  logic              mdm_irq_src,
    output logic              lan_srst,
    output logic              mdm_srst,
    output logic              lan_en,
    output logic              mdm_en,
    output logic              lan_pd_pin,
    output logic              mdm_pd_pin,
    output logic              lan_io_hit,
    output logic              mdm_io_hit,
    output logic              ireq_n,
    output logic              stschg_n
);

    opt_t              opt_a   [NFUNC];
    logic              pwr_a   [NFUNC];
    logic [IO_AW-1:0]  base_a  [NFUNC];
    logic [DATA_W-1:0] rdata_a [NFUNC];
    logic              src_a   [NFUNC];
    logic              strap_a [NFUNC];
    logic              pd_a    [NFUNC];
    logic              hit_a   [NFUNC];
    logic              req_a   [NFUNC];

    assign src_a[FN_LAN]   = lan_irq_src;
    assign src_a[FN_MDM]   = mdm_irq_src;
    assign strap_a[FN_LAN] = strap_lan_pd_hi;
    assign strap_a[FN_MDM] = strap_mdm_pd_hi;

    for (genvar i = 0; i < NFUNC; i++) begin : g_fn
        logic strap_q;

        ccr_func #(
            .FUNC_OFS  (func_ofs(i)),
            .HAS_STEER (i == FN_MDM)
        ) u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr      (attr_wr),
            .addr    (attr_addr),
            .wdata   (attr_wdata),
            .irq_src (src_a[i]),
            .rdata   (rdata_a[i]),
            .opt     (opt_a[i]),
            .pwr     (pwr_a[i]),
            .base    (base_a[i])
        );

        ccr_io_match u_match (
            .io_addr (io_addr),
            .base    (base_a[i]),
            .fn_en   (opt_a[i].fn_en),
            .lim_en  (opt_a[i].lim_en),
            .pass    (hit_a[i])
        );

        // strap sampled only while reset is held
        always_ff @(posedge clk) begin
            if (rst) strap_q <= strap_a[i];
        end

        assign pd_a[i]  = strap_q ? pwr_a[i] : ~pwr_a[i];
        assign req_a[i] = opt_a[i].fn_en & opt_a[i].irq_en & src_a[i];
    end

    assign attr_rdata = rdata_a[FN_LAN] | rdata_a[FN_MDM];

    assign lan_srst   = opt_a[FN_LAN].srst;
    assign mdm_srst   = opt_a[FN_MDM].srst;
    assign lan_en     = opt_a[FN_LAN].fn_en;
    assign mdm_en     = opt_a[FN_MDM].fn_en;
    assign lan_pd_pin = pd_a[FN_LAN];
    assign mdm_pd_pin = pd_a[FN_MDM];
    assign lan_io_hit = hit_a[FN_LAN];
    assign mdm_io_hit = hit_a[FN_MDM];

    assign ireq_n   = ~(req_a[FN_LAN] | (req_a[FN_MDM] & ~opt_a[FN_MDM].steer));
    assign stschg_n = ~(req_a[FN_MDM] & opt_a[FN_MDM].steer);

    AST_LAN_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        lan_io_hit |-> lan_en) // R5
        else $error("disabled LAN claimed I/O");

    AST_MDM_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        mdm_io_hit |-> mdm_en) // R5
        else $error("disabled modem claimed I/O");

    AST_STSCHG_FROM_MODEM: assert property (@(posedge clk) disable iff (rst)
        !stschg_n |-> (mdm_irq_src && mdm_en)) // R7
        else $error("status-change without modem source");

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lan_en && opt_a[FN_LAN].irq_en && lan_irq_src && !attr_wr)
        |=> (!lan_irq_src || !ireq_n)) // R7
        else $error("level request dropped while source held");

    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        attr_addr[0] |-> (attr_rdata == '0)) // R2
        else $error("odd offset returned data");

    AST_PD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !attr_wr |=> ($stable(lan_pd_pin) && $stable(mdm_pd_pin))) // R9
        else $error("power-down pin moved without write");

endmodule

// File: tb/sim_ccr_dual_cfg.sv
module sim_ccr_dual_cfg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        attr_wr = 1'b0;
    logic [9:0]  attr_addr = '0;
    logic [7:0]  attr_wdata = '0;
    logic [7:0]  attr_rdata;
    logic [15:0] io_addr = '0;
    logic        strap_lan_pd_hi = 1'b1;
    logic        strap_mdm_pd_hi = 1'b0;
    logic        lan_irq_src = 1'b0;
    logic        mdm_irq_src = 1'b0;
    logic        lan_srst, mdm_srst, lan_en, mdm_en;
    logic        lan_pd_pin, mdm_pd_pin, lan_io_hit, mdm_io_hit;
    logic        ireq_n, stschg_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ccr_dual_cfg u0 (
        .clk(clk), .rst(rst), .attr_wr(attr_wr), .attr_addr(attr_addr),
        .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .io_addr(io_addr),
        .strap_lan_pd_hi(strap_lan_pd_hi), .strap_mdm_pd_hi(strap_mdm_pd_hi),
        .lan_irq_src(lan_irq_src), .mdm_irq_src(mdm_irq_src),
        .lan_srst(lan_srst), .mdm_srst(mdm_srst), .lan_en(lan_en), .mdm_en(mdm_en),
        .lan_pd_pin(lan_pd_pin), .mdm_pd_pin(mdm_pd_pin),
        .lan_io_hit(lan_io_hit), .mdm_io_hit(mdm_io_hit),
        .ireq_n(ireq_n), .stschg_n(stschg_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        attr_wr = 1'b1; attr_addr = a; attr_wdata = d;
        @(negedge clk);
        attr_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
        @(negedge clk);
        attr_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), {8'h0, attr_rdata}, {8'h0, exp});
    endtask

    task automatic io_chk(input string req, input logic [15:0] a,
                          input logic exp_lan, input logic exp_mdm);
        @(negedge clk);
        io_addr = a;
        #1;
        chk(req, $sformatf("lan hit %h", a), {15'h0, lan_io_hit}, {15'h0, exp_lan});
        chk(req, $sformatf("mdm hit %h", a), {15'h0, mdm_io_hit}, {15'h0, exp_mdm});
    endtask

    task automatic pins_chk(input string req, input string what,
                            input logic exp_ireq_n, input logic exp_stschg_n);
        #1;
        chk(req, {what, " ireq_n"},   {15'h0, ireq_n},   {15'h0, exp_ireq_n});
        chk(req, {what, " stschg_n"}, {15'h0, stschg_n}, {15'h0, exp_stschg_n});
    endtask

    task automatic t_reset_state();
        rd_chk("R1", 10'h3C0, 8'h40);
        rd_chk("R1", 10'h3E0, 8'h40);
        rd_chk("R1", 10'h3C2, 8'h00);
        rd_chk("R1", 10'h3EC, 8'h00);
        pins_chk("R1", "reset", 1'b1, 1'b1);
        chk("R1", "srst", {lan_srst, mdm_srst}, 16'h0);
        chk("R1", "en",   {lan_en, mdm_en},     16'h0);
        chk("R1", "hit",  {lan_io_hit, mdm_io_hit}, 16'h0);
        chk("R9", "pd pins after reset", {lan_pd_pin, mdm_pd_pin}, 16'h1);
    endtask

    task automatic t_decode();
        wr(10'h3CA, 8'h34); wr(10'h3CC, 8'h12);
        wr(10'h3EA, 8'h78); wr(10'h3EC, 8'h56);
        rd_chk("R2", 10'h3CA, 8'h34);
        rd_chk("R2", 10'h3CC, 8'h12);
        rd_chk("R2", 10'h3EA, 8'h78);
        rd_chk("R2", 10'h3EC, 8'h56);
        rd_chk("R2", 10'h3CB, 8'h00);
        wr(10'h3CB, 8'hFF);
        wr(10'h3C4, 8'hFF);
        wr(10'h3C1, 8'hFF);
        rd_chk("R2", 10'h3C4, 8'h00);
        rd_chk("R2", 10'h3CA, 8'h34);
        rd_chk("R2", 10'h3CC, 8'h12);
        rd_chk("R2", 10'h3C0, 8'h40);
    endtask

    task automatic t_option_fields();
        wr(10'h3C0, 8'h3F);
        rd_chk("R3", 10'h3C0, 8'h47);
        wr(10'h3E0, 8'h3F);
        rd_chk("R3", 10'h3E0, 8'h4F);
        wr(10'h3C0, 8'h00);
        wr(10'h3E0, 8'h00);
        rd_chk("R3", 10'h3E0, 8'h40);
    endtask

    task automatic t_soft_reset();
        wr(10'h3C2, 8'h04);
        wr(10'h3C0, 8'h07);
        wr(10'h3C0, 8'h87);
        #1;
        chk("R4", "lan_srst", {15'h0, lan_srst}, 16'h1);
        chk("R4", "mdm_srst", {15'h0, mdm_srst}, 16'h0);
        chk("R4", "lan_en", {15'h0, lan_en}, 16'h0);
        rd_chk("R4", 10'h3C0, 8'hC0);
        rd_chk("R4", 10'h3C2, 8'h00);
        rd_chk("R4", 10'h3CA, 8'h00);
        wr(10'h3CA, 8'h55);
        rd_chk("R4", 10'h3CA, 8'h00);
        rd_chk("R4", 10'h3EA, 8'h78);
        wr(10'h3C0, 8'h00);
        #1;
        chk("R4", "lan_srst released", {15'h0, lan_srst}, 16'h0);
        rd_chk("R4", 10'h3C0, 8'h40);
        rd_chk("R4", 10'h3CC, 8'h00);
    endtask

    task automatic t_enable_gate();
        lan_irq_src = 1'b1;
        wr(10'h3C0, 8'h06);
        pins_chk("R5", "lan disabled", 1'b1, 1'b1);
        chk("R5", "lan_en off", {15'h0, lan_en}, 16'h0);
        io_chk("R5", 16'h0000, 1'b0, 1'b0);
        wr(10'h3C0, 8'h07);
        pins_chk("R7", "lan enabled", 1'b0, 1'b1);
        chk("R5", "lan_en on", {15'h0, lan_en}, 16'h1);
        repeat (4) begin
            @(negedge clk);
            pins_chk("R7", "lan level hold", 1'b0, 1'b1);
        end
        lan_irq_src = 1'b0;
        pins_chk("R7", "lan source drop", 1'b1, 1'b1);
        wr(10'h3C0, 8'h00);
    endtask

    task automatic t_io_window();
        wr(10'h3CA, 8'h40); wr(10'h3CC, 8'h03);
        wr(10'h3C0, 8'h01);
        io_chk("R6", 16'h1234, 1'b1, 1'b0);
        wr(10'h3C0, 8'h03);
        io_chk("R6", 16'h0340, 1'b1, 1'b0);
        io_chk("R6", 16'h035F, 1'b1, 1'b0);
        io_chk("R6", 16'h0360, 1'b0, 1'b0);
        io_chk("R6", 16'h033F, 1'b0, 1'b0);
        wr(10'h3EA, 8'hF8); wr(10'h3EC, 8'h02);
        wr(10'h3E0, 8'h03);
        io_chk("R6", 16'h02FF, 1'b0, 1'b1);
        io_chk("R6", 16'h02E0, 1'b0, 1'b1);
        io_chk("R6", 16'h0300, 1'b0, 1'b0);
        wr(10'h3C0, 8'h00);
        wr(10'h3E0, 8'h00);
        io_chk("R5", 16'h02E0, 1'b0, 1'b0);
    endtask

    task automatic t_irq_route();
        mdm_irq_src = 1'b1;
        wr(10'h3E0, 8'h05);
        pins_chk("R7", "modem to ireq", 1'b0, 1'b1);
        wr(10'h3E0, 8'h0D);
        pins_chk("R7", "modem steered", 1'b1, 1'b0);
        repeat (3) begin
            @(negedge clk);
            pins_chk("R7", "steered level hold", 1'b1, 1'b0);
        end
        wr(10'h3E0, 8'h09);
        pins_chk("R7", "steer without irq_en", 1'b1, 1'b1);
        wr(10'h3E0, 8'h0C);
        pins_chk("R5", "steer while disabled", 1'b1, 1'b1);
        wr(10'h3E0, 8'h0D);
        mdm_irq_src = 1'b0;
        pins_chk("R7", "steered source low", 1'b1, 1'b1);
        wr(10'h3E0, 8'h00);
    endtask

    task automatic t_status_intr();
        lan_irq_src = 1'b1;
        rd_chk("R8", 10'h3C2, 8'h02);
        wr(10'h3C2, 8'h02);
        lan_irq_src = 1'b0;
        rd_chk("R8", 10'h3C2, 8'h00);
        mdm_irq_src = 1'b1;
        rd_chk("R8", 10'h3E2, 8'h02);
        rd_chk("R8", 10'h3C2, 8'h00);
        wr(10'h3E0, 8'h80);
        rd_chk("R8", 10'h3E2, 8'h00);
        wr(10'h3E0, 8'h00);
        mdm_irq_src = 1'b0;
    endtask

    task automatic t_power_down();
        wr(10'h3C2, 8'h04);
        #1;
        chk("R9", "lan pd active high", {15'h0, lan_pd_pin}, 16'h1);
        rd_chk("R9", 10'h3C2, 8'h04);
        wr(10'h3E2, 8'h04);
        #1;
        chk("R9", "mdm pd active low", {15'h0, mdm_pd_pin}, 16'h0);
        wr(10'h3C2, 8'h00);
        wr(10'h3E2, 8'h00);
        #1;
        chk("R9", "pd cleared", {lan_pd_pin, mdm_pd_pin}, 16'h1);
    endtask

    task automatic t_straps();
        @(negedge clk);
        strap_lan_pd_hi = 1'b0;
        strap_mdm_pd_hi = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R9", "straps ignored after reset", {lan_pd_pin, mdm_pd_pin}, 16'h1);
        do_reset();
        #1;
        chk("R9", "straps relatched", {lan_pd_pin, mdm_pd_pin}, 16'h2);
        rd_chk("R1", 10'h3EA, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        t_reset_state();
        t_decode();
        t_option_fields();
        t_soft_reset();
        t_enable_gate();
        t_io_window();
        t_irq_route();
        t_status_intr();
        t_power_down();
        t_straps();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule